// File: doc/BRIEF.md
# Credit-Based Task Chain Scheduler

This block sits between the packet parser and a set of processing regions. Each region hosts one chain of processing tasks. An arriving header carries a descriptor: a packet identifier, a payload-store address, a skip mask over the tasks of a chain, and a list of one or more stages. Each stage names the set of chains that run in parallel on the packet at that step. The scheduler keeps each in-flight header in a slot of a join buffer. After a fixed decision latency, it sends the header to one instance of every chain the current stage names. Each dispatch spends one credit of the chosen region, and that single credit covers the whole chain.

Regions return the header once their chain has finished, and the credit comes back with it. Once every branch of a stage has returned, the header moves on to its next stage. After the last stage it leaves on the transmit port together with its identifier and address. When a chain runs on several regions, successive packets rotate across those regions. A pause mask takes regions out of selection while they are being reconfigured. Headers that arrive meanwhile are held, and they are served in arrival order ahead of later traffic.

Top module: `chain_credit_sched`

## Requirements
- R1: After reset `hdr_ready` is 1 and `disp_valid` and `tx_valid` are 0. `hdr_ready` is 1 exactly when a join-buffer slot is free, so with all NSLOT slots occupied it reads 0. It reads 1 again once a packet has left on the transmit port.
- R2: On an idle scheduler with credit available, `disp_valid` rises exactly LAT clock cycles after the edge that accepted the header. Two dispatches are never on consecutive cycles.
- R3: A dispatch carries the packet's skip mask unchanged on `disp_skip`. Bit k set means task k of the chain is bypassed, and the whole chain runs on one credit.
- R4: Each dispatch spends one credit of each chosen region. A region whose credit count is zero is never chosen. A return on `ret_valid[r]` gives the credit back, and a count never exceeds CREDITS.
- R5: The regions hosting chain c are the bits set in `inst_map[c*NREG +: NREG]`. Successive dispatches of chain c go to the next eligible hosting region after the one last used, in ascending index order with wrap-around, starting from region 0.
- R6: A stage is bit s of the mask `hdr_stages[s*NCHAIN +: NCHAIN]`, stage 0 first, and bit c set means chain c runs at that stage. All chains of a stage are dispatched in the same cycle with the same `disp_slot`.
- R7: A packet starts its next stage, or leaves, only after every region dispatched for the current stage has returned it.
- R8: After its last stage (`hdr_nstage` stages, 1 to NSTAGE), a packet appears once on `tx_valid` with its `hdr_id` and `hdr_addr`.
- R9: A region whose `pause_mask` bit is set receives no dispatch. Headers accepted during the pause are dispatched in arrival order once the pause is lifted.
- R10: A header whose chain has no eligible region with credit waits, without dispatch, until a credit returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inst_map | input | NCHAIN*NREG | Per chain, the regions hosting it |
| pause_mask | input | NREG | Regions withheld from selection |
| hdr_valid | input | 1 | Header offered |
| hdr_ready | output | 1 | Header accepted this cycle when valid |
| hdr_id | input | IDW | Packet identifier |
| hdr_addr | input | AW | Payload-store address |
| hdr_nstage | input | $clog2(NSTAGE+1) | Number of stages |
| hdr_stages | input | NSTAGE*NCHAIN | Chain mask per stage |
| hdr_skip | input | NTASK | Per-task bypass mask |
| disp_valid | output | NREG | Dispatch strobe per region |
| disp_slot | output | $clog2(NSLOT) | Join-buffer slot of the dispatched header |
| disp_skip | output | NTASK | Bypass mask sent with the dispatch |
| ret_valid | input | NREG | Region returns a finished header |
| ret_slot | input | NREG*$clog2(NSLOT) | Slot returned, per region |
| tx_valid | output | 1 | Packet released to transmit |
| tx_id | output | IDW | Identifier of the released packet |
| tx_addr | output | AW | Payload-store address of the released packet |

## Verification
The bench builds the block with four regions, two chains of two instances each, four slots, two stages and LAT at its default of 16. CREDITS is set to 1. With one credit per region, the third packet of a chain stalls, which makes credit exhaustion and credit return visible within a few packets. Round-robin rotation shows up as a change of region even when the previous region is free again. A two-stage packet whose first stage forks over both chains exercises the join buffer. Filling all four slots while a chain's regions are paused exercises both backpressure and in-order release.

// File: rtl/chsched_pkg.sv
package chsched_pkg;
    typedef enum logic [1:0] {
        SLOT_FREE = 2'd0,
        SLOT_RUN  = 2'd1,
        SLOT_ADV  = 2'd2
    } slot_ph_e;
endpackage

// File: rtl/chsched_rr_pick.sv
module chsched_rr_pick #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  elig,
    input  logic [IW-1:0] ptr,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        int cand;
        found = 1'b0;
        idx   = ptr;
        for (int k = 1; k <= N; k++) begin
            cand = (int'(ptr) + k) % N;
            if (!found && elig[cand]) begin
                found = 1'b1;
                idx   = IW'(cand);
            end
        end
    end
endmodule

// File: rtl/chsched_credit.sv
module chsched_credit #(
    parameter int INIT = 2,
    localparam int CW = $clog2(INIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic give,
    output logic avail
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (give && !take)      cnt_d = cnt_q + 1'b1;
        else if (take && !give) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= CW'(INIT);
        else        cnt_q <= cnt_d;
    end

    assign avail = (cnt_q != '0);

    // R4: a region is only chosen while it still holds a credit
    p_take_has_credit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (cnt_q != '0));
    // R4: a return never lifts the count above its initial value
    p_credit_ceiling_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (give && !take) |-> (int'(cnt_q) < INIT));
endmodule

// File: rtl/chsched_ready_fifo.sv
module chsched_ready_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 2,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNW  = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_a,
    input  logic [W-1:0] din_a,
    input  logic         push_b,
    input  logic [W-1:0] din_b,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         nonempty
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wp;
        logic [PW-1:0]           rp;
        logic [CNW-1:0]          cnt;
    } fifo_t;

    fifo_t f_d, f_q;

    always_comb begin
        logic [PW-1:0] w;
        f_d = f_q;
        w   = f_q.wp;
        if (push_b) begin
            f_d.mem[w] = din_b;
            w = PW'((int'(w) + 1) % DEPTH);
        end
        if (push_a) begin
            f_d.mem[w] = din_a;
            w = PW'((int'(w) + 1) % DEPTH);
        end
        f_d.wp = w;
        if (pop) f_d.rp = PW'((int'(f_q.rp) + 1) % DEPTH);
        f_d.cnt = CNW'(int'(f_q.cnt) + int'(push_a) + int'(push_b) - int'(pop));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign head     = f_q.mem[f_q.rp];
    assign nonempty = (f_q.cnt != '0);

    // R1: each slot is queued at most once, so the queue never overfills
    p_fifo_room_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (push_a || push_b) |-> (int'(f_q.cnt) + int'(push_a) + int'(push_b) - int'(pop) <= DEPTH));
endmodule

// File: rtl/chain_credit_sched.sv
module chain_credit_sched
    import chsched_pkg::*;
#(
    parameter int NREG    = 4,
    parameter int NCHAIN  = 2,
    parameter int NSLOT   = 4,
    parameter int NSTAGE  = 2,
    parameter int NTASK   = 3,
    parameter int CREDITS = 2,
    parameter int LAT     = 16,
    parameter int IDW     = 8,
    parameter int AW      = 16,
    localparam int SLW    = (NSLOT > 1) ? $clog2(NSLOT) : 1,
    localparam int RW     = (NREG > 1) ? $clog2(NREG) : 1,
    localparam int STW    = $clog2(NSTAGE + 1),
    localparam int STI    = (NSTAGE > 1) ? $clog2(NSTAGE) : 1,
    localparam int LCW    = (LAT > 1) ? $clog2(LAT) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NCHAIN*NREG-1:0]   inst_map,
    input  logic [NREG-1:0]          pause_mask,
    input  logic                     hdr_valid,
    output logic                     hdr_ready,
    input  logic [IDW-1:0]           hdr_id,
    input  logic [AW-1:0]            hdr_addr,
    input  logic [STW-1:0]           hdr_nstage,
    input  logic [NSTAGE*NCHAIN-1:0] hdr_stages,
    input  logic [NTASK-1:0]         hdr_skip,
    output logic [NREG-1:0]          disp_valid,
    output logic [SLW-1:0]           disp_slot,
    output logic [NTASK-1:0]         disp_skip,
    input  logic [NREG-1:0]          ret_valid,
    input  logic [NREG*SLW-1:0]      ret_slot,
    output logic                     tx_valid,
    output logic [IDW-1:0]           tx_id,
    output logic [AW-1:0]            tx_addr
);
    typedef struct packed {
        slot_ph_e [NSLOT-1:0]                   ph;
        logic [NSLOT-1:0][IDW-1:0]              id;
        logic [NSLOT-1:0][AW-1:0]               addr;
        logic [NSLOT-1:0][STW-1:0]              nst;
        logic [NSLOT-1:0][STI-1:0]              stg;
        logic [NSLOT-1:0][NSTAGE-1:0][NCHAIN-1:0] smask;
        logic [NSLOT-1:0][NTASK-1:0]            skip;
        logic [NSLOT-1:0][NREG-1:0]             pend;
        logic [LCW-1:0]                         cnt;
        logic [NCHAIN-1:0][RW-1:0]              rr;
        logic [NREG-1:0]                        disp_v;
        logic [SLW-1:0]                         disp_slot;
        logic [NTASK-1:0]                       disp_skip;
        logic                                   tx_v;
        logic [IDW-1:0]                         tx_id;
        logic [AW-1:0]                          tx_addr;
    } st_t;

    st_t s_d, s_q;

    logic [NREG-1:0]            avail, take;
    logic                       push_a, push_b, pop, head_v;
    logic [SLW-1:0]             din_b, head;
    logic [SLW-1:0]             fslot;
    logic                       has_free;
    logic [NCHAIN-1:0]          need, found;
    logic [NCHAIN-1:0][NREG-1:0] elig;
    logic [NCHAIN-1:0][RW-1:0]  pick;

    // free slot search
    always_comb begin
        has_free = 1'b0;
        fslot    = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (!has_free && s_q.ph[i] == SLOT_FREE) begin
                has_free = 1'b1;
                fslot    = SLW'(i);
            end
        end
    end

    assign need = s_q.smask[head][s_q.stg[head]];

    for (genvar c = 0; c < NCHAIN; c++) begin : g_chain
        assign elig[c] = inst_map[c*NREG +: NREG] & avail & ~pause_mask;
        chsched_rr_pick #(.N(NREG)) u_pick (
            .elig  (elig[c]),
            .ptr   (s_q.rr[c]),
            .found (found[c]),
            .idx   (pick[c])
        );
    end

    for (genvar r = 0; r < NREG; r++) begin : g_cred
        chsched_credit #(.INIT(CREDITS)) u_cred (
            .clk   (clk),
            .rst_n (rst_n),
            .take  (take[r]),
            .give  (ret_valid[r]),
            .avail (avail[r])
        );
    end

    chsched_ready_fifo #(.DEPTH(NSLOT), .W(SLW)) u_rdy (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_a   (push_a),
        .din_a    (fslot),
        .push_b   (push_b),
        .din_b    (din_b),
        .pop      (pop),
        .head     (head),
        .nonempty (head_v)
    );

    always_comb begin
        logic mv_done;
        s_d        = s_q;
        s_d.disp_v = '0;
        s_d.tx_v   = 1'b0;
        take       = '0;
        push_a     = 1'b0;
        push_b     = 1'b0;
        din_b      = '0;
        pop        = 1'b0;
        mv_done    = 1'b0;

        // returns clear pending branches
        for (int r = 0; r < NREG; r++) begin
            if (ret_valid[r]) s_d.pend[ret_slot[r*SLW +: SLW]][r] = 1'b0;
        end
        for (int i = 0; i < NSLOT; i++) begin
            if (s_q.ph[i] == SLOT_RUN && s_q.pend[i] != '0 && s_d.pend[i] == '0)
                s_d.ph[i] = SLOT_ADV;
        end

        // one joined slot per cycle advances or leaves
        for (int i = 0; i < NSLOT; i++) begin
            if (!mv_done && s_q.ph[i] == SLOT_ADV) begin
                mv_done = 1'b1;
                if (int'(s_q.stg[i]) + 1 < int'(s_q.nst[i])) begin
                    s_d.stg[i] = s_q.stg[i] + 1'b1;
                    s_d.ph[i]  = SLOT_RUN;
                    push_b     = 1'b1;
                    din_b      = SLW'(i);
                end else begin
                    s_d.ph[i]   = SLOT_FREE;
                    s_d.tx_v    = 1'b1;
                    s_d.tx_id   = s_q.id[i];
                    s_d.tx_addr = s_q.addr[i];
                end
            end
        end

        // new header into a free slot
        if (hdr_valid && has_free) begin
            s_d.ph[fslot]    = SLOT_RUN;
            s_d.id[fslot]    = hdr_id;
            s_d.addr[fslot]  = hdr_addr;
            s_d.nst[fslot]   = hdr_nstage;
            s_d.stg[fslot]   = '0;
            s_d.smask[fslot] = hdr_stages;
            s_d.skip[fslot]  = hdr_skip;
            s_d.pend[fslot]  = '0;
            push_a           = 1'b1;
        end

        // issue the queue head after the decision latency
        if (head_v) begin
            if (int'(s_q.cnt) < LAT - 1) begin
                s_d.cnt = s_q.cnt + 1'b1;
            end else if ((found | ~need) == '1) begin
                for (int c = 0; c < NCHAIN; c++) begin
                    if (need[c]) begin
                        s_d.disp_v[pick[c]]     = 1'b1;
                        take[pick[c]]           = 1'b1;
                        s_d.pend[head][pick[c]] = 1'b1;
                        s_d.rr[c]               = pick[c];
                    end
                end
                s_d.disp_slot = head;
                s_d.disp_skip = s_q.skip[head];
                s_d.cnt       = '0;
                pop           = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
            for (int c = 0; c < NCHAIN; c++) s_q.rr[c] <= RW'(NREG - 1);
        end else begin
            s_q <= s_d;
        end
    end

    assign hdr_ready  = has_free;
    assign disp_valid = s_q.disp_v;
    assign disp_slot  = s_q.disp_slot;
    assign disp_skip  = s_q.disp_skip;
    assign tx_valid   = s_q.tx_v;
    assign tx_id      = s_q.tx_id;
    assign tx_addr    = s_q.tx_addr;

    // R9: a withheld region sees no dispatch
    p_no_paused_disp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|disp_valid) |-> ((disp_valid & $past(pause_mask)) == '0));

    if (LAT > 1) begin : g_spacing
        // R2: each decision spends the full latency, so dispatches never abut
        p_disp_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (|disp_valid) |=> !(|disp_valid));
    end
endmodule

// File: tb/tb_chain_credit_sched.sv
module tb_chain_credit_sched;
    localparam int CLK_P  = 10;
    localparam int NREG   = 4;
    localparam int NCHAIN = 2;
    localparam int NSLOT  = 4;
    localparam int NSTAGE = 2;
    localparam int NTASK  = 3;
    localparam int LAT    = 16;
    localparam int SLW    = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [NCHAIN*NREG-1:0] inst_map = 8'b1100_0011;
    logic [NREG-1:0] pause_mask = '0;
    logic hdr_valid = 1'b0, hdr_ready;
    logic [7:0] hdr_id = '0;
    logic [15:0] hdr_addr = '0;
    logic [1:0] hdr_nstage = '0;
    logic [NSTAGE*NCHAIN-1:0] hdr_stages = '0;
    logic [NTASK-1:0] hdr_skip = '0;
    logic [NREG-1:0] disp_valid;
    logic [SLW-1:0] disp_slot;
    logic [NTASK-1:0] disp_skip;
    logic [NREG-1:0] ret_valid = '0;
    logic [NREG*SLW-1:0] ret_slot = '0;
    logic tx_valid;
    logic [7:0] tx_id;
    logic [15:0] tx_addr;

    chain_credit_sched #(.NREG(NREG), .NCHAIN(NCHAIN), .NSLOT(NSLOT), .NSTAGE(NSTAGE),
        .NTASK(NTASK), .CREDITS(1), .LAT(LAT), .IDW(8), .AW(16)) dut (
        .clk(clk), .rst_n(rst_n), .inst_map(inst_map), .pause_mask(pause_mask),
        .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_id(hdr_id), .hdr_addr(hdr_addr),
        .hdr_nstage(hdr_nstage), .hdr_stages(hdr_stages), .hdr_skip(hdr_skip),
        .disp_valid(disp_valid), .disp_slot(disp_slot), .disp_skip(disp_skip),
        .ret_valid(ret_valid), .ret_slot(ret_slot),
        .tx_valid(tx_valid), .tx_id(tx_id), .tx_addr(tx_addr));

    always #(CLK_P/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int nchk = 0, nfail = 0, ntx = 0;
    int dcount = 0, dcyc = 0, acc_cyc = 0;
    logic [NREG-1:0] dmask;
    logic [NTASK-1:0] dskip;
    int rq [NREG][$];
    logic [23:0] expq [$];
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // monitor: dispatches feed the region models, releases are scored
    always @(negedge clk) begin
        if (rst_n && |disp_valid) begin
            dcount++;
            dcyc  = cyc;
            dmask = disp_valid;
            dskip = disp_skip;
            for (int r = 0; r < NREG; r++) if (disp_valid[r]) rq[r].push_back(int'(disp_slot));
        end
        if (rst_n && tx_valid) begin
            ntx++;
            if (expq.size() == 0) begin
                chk(0, "R8", "unexpected release id", int'(tx_id), -1);
            end else begin
                logic [23:0] e;
                e = expq.pop_front();
                chk({tx_id, tx_addr} == e, "R8", "release id/addr", int'({tx_id, tx_addr}), int'(e));
            end
        end
    end

    task automatic send(input int id, input int addr, input int nst, input int stages, input int skip);
        do @(negedge clk); while (!hdr_ready);
        hdr_valid  = 1'b1;
        hdr_id     = 8'(id);
        hdr_addr   = 16'(addr);
        hdr_nstage = 2'(nst);
        hdr_stages = 4'(stages);
        hdr_skip   = 3'(skip);
        expq.push_back({8'(id), 16'(addr)});
        @(negedge clk);
        acc_cyc   = cyc;
        hdr_valid = 1'b0;
    endtask

    task automatic wait_disp(input string req);
        int start;
        int n;
        start = dcount;
        n = 0;
        while (dcount == start && n < 200) begin
            @(negedge clk);
            n++;
        end
        chk(dcount != start, req, "dispatch seen", dcount - start, 1);
    endtask

    task automatic no_disp(input int n, input string req);
        int start;
        start = dcount;
        repeat (n) @(negedge clk);
        chk(dcount == start, req, "dispatches while held", dcount - start, 0);
    endtask

    task automatic ret(input int r);
        int s;
        @(negedge clk);
        s = rq[r].pop_front();
        ret_valid[r] = 1'b1;
        ret_slot[r*SLW +: SLW] = SLW'(s);
        @(negedge clk);
        ret_valid[r] = 1'b0;
    endtask

    task automatic wait_tx();
        int n;
        n = 0;
        while (expq.size() != 0 && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk(expq.size() == 0, "R8", "pending releases", expq.size(), 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog run did not complete actual=0 expected=1");
        finish_run();
    end

    initial begin
        int txb;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(hdr_ready == 1'b1, "R1", "ready after reset", int'(hdr_ready), 1);
        chk(disp_valid == '0, "R1", "no dispatch after reset", int'(disp_valid), 0);
        chk(tx_valid == 1'b0, "R1", "no release after reset", int'(tx_valid), 0);

        // latency, skip mask, first instance
        send(1, 'h100, 1, 4'b0001, 3'b010);
        wait_disp("R2");
        chk(dcyc - acc_cyc == LAT, "R2", "decision latency", dcyc - acc_cyc, LAT);
        chk(dmask == 4'b0001, "R5", "first instance of chain 0", int'(dmask), 1);
        chk(dskip == 3'b010, "R3", "skip mask forwarded", int'(dskip), 2);
        ret(0);
        wait_tx();

        // rotation even though region 0 is free again
        send(2, 'h200, 1, 4'b0001, 3'b000);
        wait_disp("R5");
        chk(dmask == 4'b0010, "R5", "next instance of chain 0", int'(dmask), 2);
        ret(1);
        wait_tx();

        // fork over both chains, then chain 1 alone
        send(3, 'h300, 2, 4'b1011, 3'b101);
        wait_disp("R6");
        chk(dmask == 4'b0101, "R6", "fork to one region of each chain", int'(dmask), 5);
        chk(dskip == 3'b101, "R3", "skip mask on forked copies", int'(dskip), 5);
        txb = ntx;
        ret(0);
        no_disp(24, "R7");
        chk(ntx == txb, "R7", "no release with a branch open", ntx - txb, 0);
        ret(2);
        wait_disp("R7");
        chk(dmask == 4'b1000, "R7", "second stage after join", int'(dmask), 8);
        chk(ntx == txb, "R7", "no release before final stage", ntx - txb, 0);
        ret(3);
        wait_tx();

        // credit exhaustion and return
        send(4, 'h400, 1, 4'b0001, 3'b000);
        send(5, 'h500, 1, 4'b0001, 3'b000);
        send(6, 'h600, 1, 4'b0001, 3'b000);
        wait_disp("R5");
        chk(dmask == 4'b0010, "R5", "pkt4 instance", int'(dmask), 2);
        wait_disp("R4");
        chk(dmask == 4'b0001, "R4", "pkt5 on remaining credit", int'(dmask), 1);
        no_disp(40, "R10");
        ret(1);
        wait_disp("R4");
        chk(dmask == 4'b0010, "R4", "returned credit reused", int'(dmask), 2);
        ret(0);
        ret(1);
        wait_tx();

        // pause: hold, fill slots, release in order
        @(negedge clk);
        pause_mask = 4'b0011;
        send(7, 'h700, 1, 4'b0001, 3'b001);
        send(8, 'h800, 1, 4'b0001, 3'b001);
        send(9, 'h900, 1, 4'b0001, 3'b001);
        send(10, 'hA00, 1, 4'b0001, 3'b001);
        chk(hdr_ready == 1'b0, "R1", "ready with all slots taken", int'(hdr_ready), 0);
        no_disp(30, "R9");
        pause_mask = 4'b0000;
        wait_disp("R9");
        chk(dmask == 4'b0001, "R9", "first held packet", int'(dmask), 1);
        wait_disp("R9");
        chk(dmask == 4'b0010, "R9", "second held packet", int'(dmask), 2);
        ret(0);
        wait_disp("R10");
        chk(dmask == 4'b0001, "R10", "third held packet after credit", int'(dmask), 1);
        ret(1);
        wait_disp("R10");
        chk(dmask == 4'b0010, "R10", "fourth held packet after credit", int'(dmask), 2);
        chk(hdr_ready == 1'b1, "R1", "ready after a release", int'(hdr_ready), 1);
        ret(0);
        ret(1);
        wait_tx();

        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule